// File: doc/BRIEF.md
# Transmit Page Sequencer

This block streams a whole screen page out of a terminal, one character at a time. When the operator presses the send-page button, the block enters a page-sending mode. In each load phase of the terminal's repeating processor cycle it strobes the serial and parallel transmit buffers, so that both take the character at the current cursor address. It then waits for that character to finish before it pulses the cursor-advance line, which moves the cursor to the next memory location. The character store, the cursor counters and the UART are outside the block.

Completion depends on the duplex setting. In half duplex, empty transmit buffers are enough, and the block makes the data-available event itself. In full duplex, the remote end must also echo the character back before the cursor moves. The page ends when the cursor has wrapped back to the start of the page after at least one character has gone out. The block sees this at the next load phase, as the point where a scroll would otherwise happen. It then leaves the mode without loading another character, and no scroll takes place.

All outputs are registered. Each output reacts one clock after the inputs that cause it. The phase input carries the code of the current processor cycle. Three parameters select which codes mean arm, load and advance.

Top module: `transmit_page_seq`

## Requirements
- R1: With the mode idle, `start_btn` high in a cycle where `phase` equals the arm code (default 7) sets `page_active` on the next clock. A press in any other phase has no effect.
- R2: While active with no character outstanding, a cycle whose `phase` equals the load code (default 2) gives a one-clock `buf_load` pulse on the next clock. That single strobe loads every transmit buffer.
- R3: After a load, later load phases give no further `buf_load` until `cursor_adv` has pulsed for that character.
- R4: In half duplex (`full_duplex` low when the character was loaded), the cursor advances in the first advance phase (default code 4) in which every bit of `buf_empty` is 1. No advance happens while any buffer is busy.
- R5: In full duplex (`full_duplex` high when the character was loaded), the advance also needs `echo_dav` high in some cycle after the load clock and before the advance phase. An echo that arrives while no character is outstanding is ignored.
- R6: `cursor_adv` is a one-clock pulse issued only for an advance-phase cycle. It clears the outstanding character, so a repeated advance phase gives no second pulse.
- R7: In a load phase with no character outstanding and at least one character already sent, a high `cursor_at_home` clears `page_active` on the next clock and gives no `buf_load`. `cursor_at_home` is ignored before the first character of a page.
- R8: While `page_active` is high, `start_btn` is ignored. A press does not restart the page and does not release a pending load.
- R9: Synchronous active-high `rst` clears `page_active`, `buf_load` and `cursor_adv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_btn | input | 1 | Send-page button level |
| full_duplex | input | 1 | 1 = full duplex (wait for echo), 0 = half duplex |
| buf_empty | input | NUM_BUF | Per-buffer empty flags, all must be 1 to complete |
| echo_dav | input | 1 | Echoed character available from the remote end |
| phase | input | PH_W | Code of the current processor cycle phase |
| cursor_at_home | input | 1 | Cursor sits at the first location of the page |
| buf_load | output | 1 | Strobe loading the cursor character into all transmit buffers |
| cursor_adv | output | 1 | Pulse advancing the cursor by one location |
| page_active | output | 1 | Page-sending mode is running |

## Verification
A stuck outstanding-character flag shows up at the ports as the next `buf_load` either missing or doubled, one clock after the following load phase. A wrong echo or duplex record shows up as a `cursor_adv` that comes too early or never comes, and the first advance phase after the buffers drain exposes it. A wrong record of whether anything has been sent shows up as a page ending at once, or never ending, when `cursor_at_home` rises. The bench compares all three outputs against a reference model on every clock, so each of these faults appears within one processor-cycle rotation.

// File: rtl/tps_pkg.sv
package tps_pkg;

  // decoded processor-cycle strobes used by the sequencer
  typedef struct packed {
    logic arm;
    logic load;
    logic adv;
  } tick_t;

endpackage

// File: rtl/tps_phase_decode.sv
module tps_phase_decode
  import tps_pkg::*;
#(
  parameter int PH_W      = 3,
  parameter int ARM_CODE  = 7,
  parameter int LOAD_CODE = 2,
  parameter int ADV_CODE  = 4
) (
  input  logic [PH_W-1:0] phase,
  output tick_t           tick
);

  localparam logic [PH_W-1:0] ArmC  = PH_W'(ARM_CODE);
  localparam logic [PH_W-1:0] LoadC = PH_W'(LOAD_CODE);
  localparam logic [PH_W-1:0] AdvC  = PH_W'(ADV_CODE);

  always_comb begin
    tick.arm  = (phase == ArmC);
    tick.load = (phase == LoadC);
    tick.adv  = (phase == AdvC);
  end

endmodule

// File: rtl/tps_mode_ctrl.sv
module tps_mode_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic arm_tick,
  input  logic start_btn,
  input  logic load_go,
  input  logic end_hit,
  output logic start_go,
  output logic active,
  output logic sent_any
);

  logic active_q;
  logic any_q;

  // presses only count while idle and in the arm phase
  assign start_go = ~active_q & arm_tick & start_btn;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      any_q    <= 1'b0;
    end else if (start_go) begin
      active_q <= 1'b1;
      any_q    <= 1'b0;
    end else begin
      if (end_hit) active_q <= 1'b0;
      if (load_go) any_q    <= 1'b1;
    end
  end

  assign active   = active_q;
  assign sent_any = any_q;

endmodule

// File: rtl/tps_char_track.sv
module tps_char_track #(
  parameter int NUM_BUF = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               load_go,
  input  logic               adv_go,
  input  logic               full_duplex,
  input  logic               echo_dav,
  input  logic [NUM_BUF-1:0] buf_empty,
  output logic               sent,
  output logic               done_ok
);

  logic [NUM_BUF:0] empty_chain;
  logic             all_empty;
  logic             sent_q;
  logic             echo_q;
  logic             dup_q;

  assign empty_chain[0] = 1'b1;
  for (genvar g = 0; g < NUM_BUF; g++) begin : g_empty
    assign empty_chain[g+1] = empty_chain[g] & buf_empty[g];
  end
  assign all_empty = empty_chain[NUM_BUF];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sent_q <= 1'b0;
      echo_q <= 1'b0;
      dup_q  <= 1'b0;
    end else begin
      if (load_go) begin
        sent_q <= 1'b1;
        dup_q  <= full_duplex;
        echo_q <= 1'b0;
      end
      if (sent_q && echo_dav) echo_q <= 1'b1;
      if (adv_go) begin
        sent_q <= 1'b0;
        echo_q <= 1'b0;
      end
    end
  end

  // half duplex: empty buffers stand in for the data-available event
  assign done_ok = all_empty & (~dup_q | echo_q);
  assign sent    = sent_q;

endmodule

// File: rtl/transmit_page_seq.sv
module transmit_page_seq
  import tps_pkg::*;
#(
  parameter int NUM_BUF   = 2,
  parameter int PH_W      = 3,
  parameter int ARM_CODE  = 7,
  parameter int LOAD_CODE = 2,
  parameter int ADV_CODE  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_btn,
  input  logic               full_duplex,
  input  logic [NUM_BUF-1:0] buf_empty,
  input  logic               echo_dav,
  input  logic [PH_W-1:0]    phase,
  input  logic               cursor_at_home,
  output logic               buf_load,
  output logic               cursor_adv,
  output logic               page_active
);

  tick_t tick;
  logic  start_go, active, sent_any, sent, done_ok;
  logic  load_slot, end_hit, load_go, adv_go;
  logic  load_q, adv_q;

  tps_phase_decode #(
    .PH_W(PH_W), .ARM_CODE(ARM_CODE), .LOAD_CODE(LOAD_CODE), .ADV_CODE(ADV_CODE)
  ) u_dec (
    .phase(phase),
    .tick (tick)
  );

  // a load slot with a wrapped cursor is the suppressed scroll point
  assign load_slot = active & tick.load & ~sent;
  assign end_hit   = load_slot & sent_any & cursor_at_home;
  assign load_go   = load_slot & ~end_hit;
  assign adv_go    = active & tick.adv & sent & done_ok;

  tps_mode_ctrl u_mode (
    .clk      (clk),
    .rst      (rst),
    .arm_tick (tick.arm),
    .start_btn(start_btn),
    .load_go  (load_go),
    .end_hit  (end_hit),
    .start_go (start_go),
    .active   (active),
    .sent_any (sent_any)
  );

  tps_char_track #(.NUM_BUF(NUM_BUF)) u_track (
    .clk        (clk),
    .rst        (rst),
    .clear      (start_go),
    .load_go    (load_go),
    .adv_go     (adv_go),
    .full_duplex(full_duplex),
    .echo_dav   (echo_dav),
    .buf_empty  (buf_empty),
    .sent       (sent),
    .done_ok    (done_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      load_q <= load_go;
      adv_q  <= adv_go;
    end
  end

  assign buf_load    = load_q;
  assign cursor_adv  = adv_q;
  assign page_active = active;

endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int NUM_BUF = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               start_btn,
  input logic               full_duplex,
  input logic [NUM_BUF-1:0] buf_empty,
  input logic               echo_dav,
  input logic               cursor_at_home,
  input logic               buf_load,
  input logic               cursor_adv,
  input logic               page_active
);

  logic pend_q, echo_q, dup_prev_q, dup_q, pend_now;

  // port-level view of the outstanding character
  assign pend_now = (pend_q | buf_load) & ~cursor_adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      echo_q     <= 1'b0;
      dup_prev_q <= 1'b0;
      dup_q      <= 1'b0;
    end else begin
      pend_q     <= pend_now;
      dup_prev_q <= full_duplex;
      if (buf_load) dup_q <= dup_prev_q;
      if (cursor_adv) echo_q <= 1'b0;
      else if (pend_now && echo_dav) echo_q <= 1'b1;
    end
  end

  AST_START_NEEDS_PRESS: assert property (@(posedge clk) disable iff (rst)
    $rose(page_active) |-> $past(start_btn)); // R1
  AST_LOAD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    buf_load |-> page_active); // R2
  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    buf_load |-> !pend_q); // R3
  AST_ADV_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    cursor_adv |-> $past(&buf_empty)); // R4
  AST_FULL_NEEDS_ECHO: assert property (@(posedge clk) disable iff (rst)
    (cursor_adv && dup_q) |-> echo_q); // R5
  AST_ADV_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    cursor_adv |-> pend_q); // R6
  AST_END_AT_HOME: assert property (@(posedge clk) disable iff (rst)
    $fell(page_active) |-> $past(cursor_at_home)); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!page_active && !buf_load && !cursor_adv)); // R9

endmodule

bind transmit_page_seq tps_checker #(.NUM_BUF(NUM_BUF)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start_btn     (start_btn),
  .full_duplex   (full_duplex),
  .buf_empty     (buf_empty),
  .echo_dav      (echo_dav),
  .cursor_at_home(cursor_at_home),
  .buf_load      (buf_load),
  .cursor_adv    (cursor_adv),
  .page_active   (page_active)
);

// File: tb/transmit_page_seq_test.sv
`timescale 1ns/1ps
module transmit_page_seq_test;

  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_btn = 1'b0, full_duplex = 1'b0, echo_dav = 1'b0, cursor_at_home = 1'b0;
  logic [NB-1:0] buf_empty = '0;
  logic [2:0]    phase = 3'd0;
  logic          buf_load, cursor_adv, page_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  logic m_active = 1'b0, m_sent = 1'b0, m_echo = 1'b0, m_dup = 1'b0, m_any = 1'b0;
  logic m_load = 1'b0, m_adv = 1'b0;

  transmit_page_seq #(.NUM_BUF(NB)) uut (
    .clk(clk), .rst(rst), .start_btn(start_btn), .full_duplex(full_duplex),
    .buf_empty(buf_empty), .echo_dav(echo_dav), .phase(phase),
    .cursor_at_home(cursor_at_home), .buf_load(buf_load),
    .cursor_adv(cursor_adv), .page_active(page_active)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_active <= 0; m_sent <= 0; m_echo <= 0; m_dup <= 0; m_any <= 0;
      m_load <= 0; m_adv <= 0;
    end else begin
      m_load <= 0;
      m_adv  <= 0;
      if (!m_active) begin
        if (phase == 3'd7 && start_btn) begin
          m_active <= 1; m_any <= 0; m_sent <= 0; m_echo <= 0; m_dup <= 0;
        end
      end else begin
        if (phase == 3'd2 && !m_sent) begin
          if (m_any && cursor_at_home) m_active <= 0;
          else begin
            m_load <= 1; m_sent <= 1; m_any <= 1; m_dup <= full_duplex; m_echo <= 0;
          end
        end
        if (m_sent && echo_dav) m_echo <= 1;
        if (phase == 3'd4 && m_sent && (&buf_empty) && (!m_dup || m_echo)) begin
          m_adv <= 1; m_sent <= 0; m_echo <= 0;
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // drive one cycle, then compare all outputs against the model
  task automatic cyc(input logic [2:0] ph, input logic btn, input logic fd,
                     input logic [NB-1:0] emp, input logic ech, input logic home);
    phase = ph; start_btn = btn; full_duplex = fd;
    buf_empty = emp; echo_dav = ech; cursor_at_home = home;
    @(negedge clk);
    check(page_active, m_active, "R1/R7/R8 page_active");
    check(buf_load, m_load, "R2/R3 buf_load");
    check(cursor_adv, m_adv, "R4/R5/R6 cursor_adv");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(page_active, 1'b0, "R9 active after reset");
    check(buf_load, 1'b0, "R9 load after reset");
    check(cursor_adv, 1'b0, "R9 adv after reset");
    rst = 1'b0;

    cyc(3'd5, 1, 0, 2'b00, 0, 0); check(page_active, 1'b0, "R1 press off arm phase");
    cyc(3'd7, 1, 0, 2'b00, 0, 0); check(page_active, 1'b1, "R1 press in arm phase");
    cyc(3'd2, 0, 0, 2'b00, 0, 0); check(buf_load, 1'b1, "R2 first load");
    cyc(3'd2, 0, 0, 2'b00, 0, 0); check(buf_load, 1'b0, "R3 no reload");
    cyc(3'd4, 0, 0, 2'b01, 0, 0); check(cursor_adv, 1'b0, "R4 buffer busy");
    cyc(3'd4, 0, 0, 2'b11, 0, 0); check(cursor_adv, 1'b1, "R4 half duplex advance");
    cyc(3'd2, 0, 0, 2'b00, 0, 0); check(buf_load, 1'b1, "R2 second load");
    cyc(3'd7, 1, 0, 2'b00, 0, 0); check(page_active, 1'b1, "R8 press while active");
    cyc(3'd2, 0, 0, 2'b00, 0, 0); check(buf_load, 1'b0, "R8 press released no load");
    cyc(3'd4, 0, 0, 2'b11, 0, 0); check(cursor_adv, 1'b1, "R4 advance");
    cyc(3'd2, 0, 1, 2'b00, 0, 0); check(buf_load, 1'b1, "R5 full duplex load");
    cyc(3'd4, 0, 0, 2'b11, 0, 0); check(cursor_adv, 1'b0, "R5 wait for echo");
    cyc(3'd3, 0, 0, 2'b11, 1, 0);
    cyc(3'd5, 0, 0, 2'b11, 0, 0); check(cursor_adv, 1'b0, "R6 not in other phase");
    cyc(3'd4, 0, 0, 2'b11, 0, 0); check(cursor_adv, 1'b1, "R5 echo then advance");
    cyc(3'd4, 0, 0, 2'b11, 0, 0); check(cursor_adv, 1'b0, "R6 single pulse");
    cyc(3'd3, 0, 0, 2'b11, 1, 0);
    cyc(3'd2, 0, 1, 2'b00, 0, 0); check(buf_load, 1'b1, "R5 load after stray echo");
    cyc(3'd4, 0, 0, 2'b11, 0, 0); check(cursor_adv, 1'b0, "R5 stray echo ignored");
    cyc(3'd3, 0, 0, 2'b11, 1, 0);
    cyc(3'd4, 0, 0, 2'b11, 0, 0); check(cursor_adv, 1'b1, "R5 advance after echo");
    cyc(3'd2, 0, 0, 2'b00, 0, 1); check(page_active, 1'b0, "R7 page end");
    check(buf_load, 1'b0, "R7 no load at page end");
    cyc(3'd7, 1, 0, 2'b00, 0, 1); check(page_active, 1'b1, "R1 restart");
    cyc(3'd2, 0, 0, 2'b00, 0, 1); check(buf_load, 1'b1, "R7 home ignored before first char");

    for (int i = 0; i < 20000; i++) begin
      logic [2:0] ph;
      ph = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'(i % 8);
      cyc(ph, ($urandom % 8) == 0, $urandom % 2 == 1,
          {($urandom % 4) != 0, ($urandom % 4) != 0},
          ($urandom % 4) == 0, ($urandom % 6) == 0);
    end

    rst = 1'b1;
    @(negedge clk);
    check(page_active, 1'b0, "R9 active after late reset");
    check(buf_load, 1'b0, "R9 load after late reset");
    check(cursor_adv, 1'b0, "R9 adv after late reset");
    summary();
  end

endmodule